// File: doc/BRIEF.md
# Two-Lane Word Serializer with Forwarded Clock

This block turns a parallel word into serial form. The word is cut into equal slices, and each slice goes out on its own serial lane. A clock at the word rate is sent alongside the data so that the far end can frame the slices. The word is sampled on an edge of an external word clock, and an input picks which edge is used. All shifting runs from a bit clock. That clock runs at exactly slice-width times the word rate and is phase aligned with the word clock. The multiplying PLL is outside the block.

An enable input stops the block and clears it. While enable is low, every register is cleared, the data and clock outputs sit low, and the pad drive enable is withdrawn, so the pads float. Clock, data and enable may be applied in any order. Enable does not need to be toggled when the clocks stop and later resume.

With the defaults, a 14-bit word becomes two 7-bit lanes, and the word clock may run from 10 MHz to 100 MHz.

Top module: `dual_lane_serializer`

## Requirements
- R1: Lane 0 carries word bits 6..0 and lane 1 carries word bits 13..7. In general, lane `l` carries word bits `l*7+6 .. l*7`.
- R2: When `edge_rise_i` is high, the word is taken on the rising edge of `wclk_i`. When it is low, the word is taken on the falling edge. The select is looked at only when a new word is loaded into the lanes.
- R3: Each lane sends the least significant bit of its slice first. Slice bit `i` occupies bit-clock slot `i` of the word period, so bit 6 goes last.
- R4: `fclk_o` repeats every 7 bit clocks. It is high in slots 0 to 3 and low in slots 4 to 6, so each of its rising edges marks the first slot of a word.
- R5: A word is sampled during one word period and is sent during the next word period, in full, on both lanes. The first bit-clock slot after release from reset or disable is slot 0 of a word period. Zeros are sent in that first period.
- R6: While `en_i` is low, `drive_o` is low, `lane_o` and `fclk_o` are low, and all state is cleared. While `en_i` is high, `drive_o` is high.
- R7: While `rst_n_i` is low, `lane_o` and `fclk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock, 7x the word rate, phase aligned |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low clears state and releases the pads |
| wclk_i | input | 1 | Word clock that samples `word_i` |
| edge_rise_i | input | 1 | High: sample on the rising edge; low: sample on the falling edge |
| word_i | input | 14 | Parallel input word |
| lane_o | output | 2 | Serial lane data, one bit per lane |
| fclk_o | output | 1 | Forwarded word-rate clock |
| drive_o | output | 1 | Pad drive enable; the pads float while it is low |

## Verification
Two events share the last bit clock of every word period. In that cycle the lanes shift out slice bit 6 of the old word, and the shift registers load the new word, which then appears as bit 0 together with the rising edge of `fclk_o`.

The bench provokes this boundary on every word. It changes `word_i` between the rising and falling edges of `wclk_i`, so the two sampling edges hold different values. It also flips `edge_rise_i` one slot before the boundary. Every bit clock, the bench compares the slot-6 bit, the following slot-0 bit and the forwarded clock with a behavioural model. A wrong slice, a wrong edge or an off-by-one load therefore shows up in the first slot where it occurs.

// File: rtl/dls_pkg.sv
package dls_pkg;

   // Number of bit slots in which the forwarded clock is high (rounded up).
   function automatic int clk_high_slots(input int slots);
      return (slots + 1) / 2;
   endfunction

   // Width of a counter that holds slot numbers 0 .. slots-1.
   function automatic int slot_bits(input int slots);
      return (slots <= 2) ? 1 : $clog2(slots);
   endfunction

endpackage

// File: rtl/dls_word_capture.sv
module dls_word_capture #(
   parameter int W = 14
) (
   input  logic         wclk_i,
   input  logic         arst_n_i,
   input  logic         rise_sel_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_width
      $error("dls_word_capture: W must be at least 1");
   end

   logic [W-1:0] rise_q;
   logic [W-1:0] fall_q;

   always_ff @(posedge wclk_i or negedge arst_n_i) begin
      if (!arst_n_i) rise_q <= '0;
      else           rise_q <= d_i;
   end

   always_ff @(negedge wclk_i or negedge arst_n_i) begin
      if (!arst_n_i) fall_q <= '0;
      else           fall_q <= d_i;
   end

   // The select takes effect only when the lanes load this value.
   assign q_o = rise_sel_i ? rise_q : fall_q;

endmodule

// File: rtl/dls_slot_timer.sv
module dls_slot_timer
   import dls_pkg::*;
#(
   parameter int SLOTS = 7
) (
   input  logic bclk_i,
   input  logic arst_n_i,
   output logic load_o,
   output logic fclk_o
);

   localparam int SB = slot_bits(SLOTS);
   localparam logic [SB-1:0] LAST = SB'(SLOTS - 1);
   localparam logic [SB-1:0] HIGH = SB'(clk_high_slots(SLOTS));

   if (SLOTS < 2) begin : g_bad_slots
      $error("dls_slot_timer: SLOTS must be at least 2");
   end

   logic [SB-1:0] slot_q;

   always_ff @(posedge bclk_i or negedge arst_n_i) begin
      if (!arst_n_i)           slot_q <= '0;
      else if (slot_q == LAST) slot_q <= '0;
      else                     slot_q <= slot_q + 1'b1;
   end

   assign load_o = (slot_q == LAST);
   assign fclk_o = arst_n_i & (slot_q < HIGH);

   // R4
   slot_range_chk: assert property (@(posedge bclk_i) disable iff (!arst_n_i)
      slot_q <= LAST);

   // R4
   load_wrap_chk: assert property (@(posedge bclk_i) disable iff (!arst_n_i)
      load_o |=> (slot_q == '0));

   // R4
   fclk_rise_chk: assert property (@(posedge bclk_i) disable iff (!arst_n_i)
      $rose(fclk_o) |-> (slot_q == '0));

endmodule

// File: rtl/dls_lane_shift.sv
module dls_lane_shift #(
   parameter int W = 7
) (
   input  logic         bclk_i,
   input  logic         arst_n_i,
   input  logic         load_i,
   input  logic [W-1:0] par_i,
   output logic         ser_o
);

   if (W < 2) begin : g_bad_width
      $error("dls_lane_shift: W must be at least 2");
   end

   logic [W-1:0] sh_q;

   always_ff @(posedge bclk_i or negedge arst_n_i) begin
      if (!arst_n_i)   sh_q <= '0;
      else if (load_i) sh_q <= par_i;
      else             sh_q <= {1'b0, sh_q[W-1:1]};
   end

   assign ser_o = sh_q[0];

   // R3
   first_bit_chk: assert property (@(posedge bclk_i) disable iff (!arst_n_i)
      load_i |=> (ser_o == $past(par_i[0])));

endmodule

// File: rtl/dual_lane_serializer.sv
module dual_lane_serializer
   import dls_pkg::*;
#(
   parameter int SLICE_W = 7,
   parameter int LANES   = 2
) (
   input  logic                       bclk_i,
   input  logic                       rst_n_i,
   input  logic                       en_i,
   input  logic                       wclk_i,
   input  logic                       edge_rise_i,
   input  logic [SLICE_W*LANES-1:0]   word_i,
   output logic [LANES-1:0]           lane_o,
   output logic                       fclk_o,
   output logic                       drive_o
);

   localparam int WORD_W = SLICE_W * LANES;

   if (LANES < 1) begin : g_bad_lanes
      $error("dual_lane_serializer: LANES must be at least 1");
   end

   logic              arst_n;
   logic [WORD_W-1:0] held;
   logic              load;

   assign arst_n  = rst_n_i & en_i;
   assign drive_o = en_i;

   dls_word_capture #(.W(WORD_W)) u_cap (
      .wclk_i     (wclk_i),
      .arst_n_i   (arst_n),
      .rise_sel_i (edge_rise_i),
      .d_i        (word_i),
      .q_o        (held)
   );

   dls_slot_timer #(.SLOTS(SLICE_W)) u_tmr (
      .bclk_i   (bclk_i),
      .arst_n_i (arst_n),
      .load_o   (load),
      .fclk_o   (fclk_o)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      dls_lane_shift #(.W(SLICE_W)) u_sh (
         .bclk_i   (bclk_i),
         .arst_n_i (arst_n),
         .load_i   (load),
         .par_i    (held[l*SLICE_W +: SLICE_W]),
         .ser_o    (lane_o[l])
      );
   end

   // R6
   idle_low_chk: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
      !en_i |-> (lane_o == '0 && !fclk_o && !drive_o));

endmodule

// File: tb/sim_dual_lane_serializer.sv
module sim_dual_lane_serializer;
   localparam int SW = 7;
   localparam int NL = 2;
   localparam int WW = SW * NL;
   localparam int HI = 4;

   logic          bclk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b1;
   logic          wclk = 1'b0;
   logic          rise = 1'b1;
   logic [WW-1:0] word = '0;
   logic [NL-1:0] lane;
   logic          fclk;
   logic          drive;

   int checks = 0;
   int errors = 0;

   dual_lane_serializer #(.SLICE_W(SW), .LANES(NL)) u0 (
      .bclk_i(bclk), .rst_n_i(rst_n), .en_i(en), .wclk_i(wclk),
      .edge_rise_i(rise), .word_i(word), .lane_o(lane), .fclk_o(fclk),
      .drive_o(drive)
   );

   always #4 bclk = ~bclk;

   // Behavioural model state.
   logic [WW-1:0] r_cap = '0, f_cap = '0, send = '0, send_nx = '0;
   logic          rise_next = 1'b1;
   int            ph = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Called at a falling edge of bclk: compare first, then drive stimulus.
   task automatic slot_step();
      chk(drive === 1'b1, "R6", int'(drive), 1);
      chk(fclk === (ph < HI), "R4", int'(fclk), int'(ph < HI));
      for (int l = 0; l < NL; l++)
         chk(lane[l] === send[l*SW+ph], "R1 R3 R5", int'(lane[l]), int'(send[l*SW+ph]));
      #1;
      case (ph)
         0: begin wclk = 1'b1; r_cap = word; end
         2: word = WW'($urandom);
         4: begin wclk = 1'b0; f_cap = word; end
         5: begin word = WW'($urandom); rise = rise_next; end
         6: send_nx = rise ? r_cap : f_cap;   // R2
         default: ;
      endcase
      ph = (ph + 1) % SW;
      if (ph == 0) send = send_nx;
   endtask

   task automatic run_slots(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge bclk);
         slot_step();
      end
   endtask

   task automatic model_clear();
      ph = 0; r_cap = '0; f_cap = '0; send = '0; send_nx = '0;
   endtask

   task automatic disable_for(input int n);
      @(negedge bclk);
      en = 1'b0;
      wclk = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge bclk);
         chk(drive === 1'b0, "R6", int'(drive), 0);
         chk(lane === '0, "R6", int'(lane), 0);
         chk(fclk === 1'b0, "R6", int'(fclk), 0);
         word = WW'($urandom);
         wclk = ~wclk;
      end
      wclk = 1'b0;
      @(posedge bclk);
      #2;
      en = 1'b1;
      model_clear();
   endtask

   initial begin
      // R7: reset state
      for (int i = 0; i < 4; i++) begin
         @(negedge bclk);
         chk(lane === '0, "R7", int'(lane), 0);
         chk(fclk === 1'b0, "R7", int'(fclk), 0);
         chk(drive === 1'b1, "R6", int'(drive), 1);
      end
      @(posedge bclk);
      #2;
      rst_n = 1'b1;
      model_clear();

      // R2: rising-edge sampling
      rise_next = 1'b1;
      run_slots(20 * SW);
      // R2: falling-edge sampling, switched just before a boundary
      rise_next = 1'b0;
      run_slots(20 * SW + 3);
      // R6: disable in the middle of a word, then restart (R5)
      disable_for(10);
      run_slots(15 * SW);
      rise_next = 1'b1;
      run_slots(12 * SW + 5);
      disable_for(3);
      rise_next = 1'b0;
      run_slots(10 * SW);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule